// File: doc/BRIEF.md
# Link Rate and Lane Fallback Stepper

This block works out the next, more modest link configuration to try after a serial display link fails to train. The training controller presents the configuration it just tried (a rate code and a lane count), together with the highest rate and the widest lane count the sink reports. It then pulses `step_i` for one cycle. On the next cycle the block shows either the new configuration with `done_o` high and `fail_o` low, or `done_o` and `fail_o` both high. In the failure case the configuration outputs return to the configuration presented with the step.

The stepping does not walk one fixed ladder. At the top rate it first narrows the link. Once a single lane at the top rate has failed, it drops to the middle rate and widens back to the full lane count. The middle rate drops to the lowest rate at the same width. The lowest rate climbs to the middle rate at half the width if the sink can run the middle rate. Otherwise it only narrows. The block does not judge whether the result has enough bandwidth for any video mode, and it issues no sideband or register traffic.

The control is a three-state machine. ST_IDLE means no result is being presented. ST_PASS means a valid new configuration is on the outputs. ST_FAIL means stepping failed and the saved configuration is on the outputs. Every state moves to ST_PASS on a step whose candidate is legal, and to ST_FAIL on a step whose candidate is illegal. With no step, every state moves to ST_IDLE.

Top module: `lnk_fallback_stepper`

## Requirements
- R1: After reset, `done_o` and `fail_o` are 0, `rate_o` is 0x00 and `lanes_o` is 0.
- R2: A step at rate 0x06 (1.62 Gb/s) with `max_rate_i` numerically above 0x06 yields rate 0x0A (2.7 Gb/s) and the lane count shifted right by one.
- R3: A step at rate 0x06 with `max_rate_i` at or below 0x06 keeps rate 0x06 and shifts the lane count right by one.
- R4: A step at rate 0x0A yields rate 0x06 with the lane count unchanged.
- R5: A step at rate 0x14 (5.4 Gb/s) with exactly one lane yields rate 0x0A and the lane count `max_lanes_i`.
- R6: A step at rate 0x14 with a lane count other than one keeps rate 0x14 and shifts the lane count right by one.
- R7: A step with any rate code other than 0x06, 0x0A or 0x14 reports failure.
- R8: A step whose resulting lane count is 0 reports failure.
- R9: When failure is reported, `rate_o` and `lanes_o` equal the rate and lane count presented with that step, even if the inputs have changed since.
- R10: `done_o` is high in exactly the cycles that follow a cycle with `step_i` high. `fail_o` is never high without `done_o`. Back-to-back steps each produce their own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_i | input | 1 | Request to step down from the presented configuration |
| cur_rate_i | input | 8 | Rate code of the configuration that failed |
| cur_lanes_i | input | 3 | Lane count of the configuration that failed |
| max_rate_i | input | 8 | Highest rate code the sink supports |
| max_lanes_i | input | 3 | Widest lane count the sink supports |
| rate_o | output | 8 | Resulting rate code (restored on failure) |
| lanes_o | output | 3 | Resulting lane count (restored on failure) |
| done_o | output | 1 | Result valid this cycle |
| fail_o | output | 1 | Stepping failed; outputs hold the saved configuration |

## Verification
The bench sweeps every combination of the three legal rates and two illegal rate codes, all eight lane counts, three sink maximum rates and three sink lane maxima. It checks each result against arithmetic worked out from the requirements. The sweep targets the single-lane top-rate jump: a design that halved the width there would report a zero-lane failure instead of widening back to `max_lanes_i`. It also targets the lowest rate on a sink limited to 1.62 Gb/s, where a design that climbed regardless would offer a rate the sink cannot run. After each step the bench scrambles the inputs before sampling the held outputs. A design that restored from the live inputs rather than a saved copy would then show garbage on failure. Back-to-back steps expose a state machine that drops to idle between requests.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
    localparam int RATE_W = 8;
    localparam int LANE_W = 3;

    localparam logic [RATE_W-1:0] RATE_LOW = 8'h06;
    localparam logic [RATE_W-1:0] RATE_MID = 8'h0A;
    localparam logic [RATE_W-1:0] RATE_TOP = 8'h14;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PASS = 2'd1,
        ST_FAIL = 2'd2
    } lfs_state_e;
endpackage

// File: rtl/lfs_next_cfg.sv
module lfs_next_cfg
    import lfs_pkg::*;
#(
    parameter int RW = RATE_W,
    parameter int LW = LANE_W
) (
    input  logic [RW-1:0] cur_rate,
    input  logic [LW-1:0] cur_lanes,
    input  logic [RW-1:0] max_rate,
    input  logic [LW-1:0] max_lanes,
    output logic [RW-1:0] nxt_rate,
    output logic [LW-1:0] nxt_lanes,
    output logic          nxt_ok
);
    localparam logic [LW-1:0] ONE_LANE = LW'(1);

    logic rate_known;

    always_comb begin
        nxt_rate   = cur_rate;
        nxt_lanes  = cur_lanes;
        rate_known = 1'b1;
        case (cur_rate)
            RW'(RATE_LOW): begin
                if (max_rate > RW'(RATE_LOW)) begin
                    nxt_rate = RW'(RATE_MID);
                end
                nxt_lanes = cur_lanes >> 1;
            end
            RW'(RATE_MID): begin
                nxt_rate = RW'(RATE_LOW);
            end
            RW'(RATE_TOP): begin
                if (cur_lanes == ONE_LANE) begin
                    nxt_rate  = RW'(RATE_MID);
                    nxt_lanes = max_lanes;
                end else begin
                    nxt_lanes = cur_lanes >> 1;
                end
            end
            default: begin
                rate_known = 1'b0;
            end
        endcase
        nxt_ok = rate_known && (nxt_lanes != '0);
    end
endmodule

// File: rtl/lfs_ctrl.sv
module lfs_ctrl
    import lfs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic cand_ok,
    output logic done,
    output logic fail
);
    lfs_state_e state_q, state_d;

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_PASS, ST_FAIL: begin
                if (step) begin
                    state_d = cand_ok ? ST_PASS : ST_FAIL;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        done = 1'b0;
        fail = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PASS: done = 1'b1;
            ST_FAIL: begin
                done = 1'b1;
                fail = 1'b1;
            end
            default: ;
        endcase
    end

    // R10: a failure is always a presented result
    a_r10_fail_has_done: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done);
    // R10: result appears on the cycle after a request
    a_r10_done_after_step: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> done);
    a_r10_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> !done);
endmodule

// File: rtl/lfs_cfg_hold.sv
module lfs_cfg_hold
    import lfs_pkg::*;
#(
    parameter int RW = RATE_W,
    parameter int LW = LANE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [RW-1:0] cur_rate,
    input  logic [LW-1:0] cur_lanes,
    input  logic [RW-1:0] cand_rate,
    input  logic [LW-1:0] cand_lanes,
    input  logic          use_saved,
    output logic [RW-1:0] rate,
    output logic [LW-1:0] lanes
);
    logic [RW-1:0] saved_rate_q, cand_rate_q;
    logic [LW-1:0] saved_lanes_q, cand_lanes_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            saved_rate_q  <= '0;
            saved_lanes_q <= '0;
            cand_rate_q   <= '0;
            cand_lanes_q  <= '0;
        end else if (step) begin
            saved_rate_q  <= cur_rate;
            saved_lanes_q <= cur_lanes;
            cand_rate_q   <= cand_rate;
            cand_lanes_q  <= cand_lanes;
        end
    end

    assign rate  = use_saved ? saved_rate_q  : cand_rate_q;
    assign lanes = use_saved ? saved_lanes_q : cand_lanes_q;
endmodule

// File: rtl/lnk_fallback_stepper.sv
module lnk_fallback_stepper
    import lfs_pkg::*;
#(
    parameter int RW = RATE_W,
    parameter int LW = LANE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic [RW-1:0] cur_rate_i,
    input  logic [LW-1:0] cur_lanes_i,
    input  logic [RW-1:0] max_rate_i,
    input  logic [LW-1:0] max_lanes_i,
    output logic [RW-1:0] rate_o,
    output logic [LW-1:0] lanes_o,
    output logic          done_o,
    output logic          fail_o
);
    logic [RW-1:0] cand_rate;
    logic [LW-1:0] cand_lanes;
    logic          cand_ok;

    lfs_next_cfg #(.RW(RW), .LW(LW)) u_next (
        .cur_rate  (cur_rate_i),
        .cur_lanes (cur_lanes_i),
        .max_rate  (max_rate_i),
        .max_lanes (max_lanes_i),
        .nxt_rate  (cand_rate),
        .nxt_lanes (cand_lanes),
        .nxt_ok    (cand_ok)
    );

    lfs_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step_i),
        .cand_ok (cand_ok),
        .done    (done_o),
        .fail    (fail_o)
    );

    lfs_cfg_hold #(.RW(RW), .LW(LW)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step_i),
        .cur_rate   (cur_rate_i),
        .cur_lanes  (cur_lanes_i),
        .cand_rate  (cand_rate),
        .cand_lanes (cand_lanes),
        .use_saved  (fail_o),
        .rate       (rate_o),
        .lanes      (lanes_o)
    );

    // R9: failure restores the configuration presented with the step
    a_r9_restore_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> (!fail_o || (rate_o == $past(cur_rate_i) && lanes_o == $past(cur_lanes_i))));
    // R4: middle rate drops to lowest rate at the same width
    a_r4_mid_to_low: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && cur_rate_i == RW'(RATE_MID) && cur_lanes_i != '0)
        |=> (!fail_o && rate_o == RW'(RATE_LOW) && lanes_o == $past(cur_lanes_i)));
    // R5: single lane at top rate widens to the sink maximum at the middle rate
    a_r5_top_single_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && cur_rate_i == RW'(RATE_TOP) && cur_lanes_i == LW'(1) && max_lanes_i != '0)
        |=> (!fail_o && rate_o == RW'(RATE_MID) && lanes_o == $past(max_lanes_i)));
    // R7: unknown rate codes fail
    a_r7_unknown_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && cur_rate_i != RW'(RATE_LOW) && cur_rate_i != RW'(RATE_MID)
         && cur_rate_i != RW'(RATE_TOP)) |=> fail_o);
    // R8: a passing result never carries zero lanes
    a_r8_no_zero_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !fail_o) |-> lanes_o != '0);
endmodule

// File: tb/lnk_fallback_stepper_bench.sv
module lnk_fallback_stepper_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_i = 1'b0;
    logic [7:0] cur_rate_i = '0;
    logic [2:0] cur_lanes_i = '0;
    logic [7:0] max_rate_i = '0;
    logic [2:0] max_lanes_i = '0;
    logic [7:0] rate_o;
    logic [2:0] lanes_o;
    logic       done_o, fail_o;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    lnk_fallback_stepper u_lnk_fallback_stepper (
        .clk(clk), .rst_n(rst_n), .step_i(step_i),
        .cur_rate_i(cur_rate_i), .cur_lanes_i(cur_lanes_i),
        .max_rate_i(max_rate_i), .max_lanes_i(max_lanes_i),
        .rate_o(rate_o), .lanes_o(lanes_o), .done_o(done_o), .fail_o(fail_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // expected result from the requirements
    task automatic expect_cfg(input int r, input int l, input int mr, input int ml,
                              output int er, output int el, output int ef, output string req);
        er = r; el = l; ef = 0;
        if (r == 'h06) begin
            el = l / 2;
            if (mr > 'h06) begin er = 'h0A; req = "R2"; end
            else req = "R3";
        end else if (r == 'h0A) begin
            er = 'h06; req = "R4";
        end else if (r == 'h14) begin
            if (l == 1) begin er = 'h0A; el = ml; req = "R5"; end
            else begin el = l / 2; req = "R6"; end
        end else begin
            ef = 1; req = "R7";
        end
        if (ef == 0 && el == 0) begin ef = 1; req = "R8"; end
        if (ef == 1) begin er = r; el = l; end
    endtask

    task automatic one_step(input int r, input int l, input int mr, input int ml);
        int er, el, ef;
        string req;
        expect_cfg(r, l, mr, ml, er, el, ef, req);
        @(negedge clk);
        cur_rate_i = 8'(r); cur_lanes_i = 3'(l);
        max_rate_i = 8'(mr); max_lanes_i = 3'(ml);
        step_i = 1'b1;
        @(negedge clk);
        step_i = 1'b0;
        // scramble inputs: held outputs must not follow them
        cur_rate_i = 8'hFF; cur_lanes_i = 3'd7; max_lanes_i = 3'd0;
        check({req, " done"}, int'(done_o), 1);
        check({req, " fail"}, int'(fail_o), ef);
        check(ef ? "R9 rate" : {req, " rate"}, int'(rate_o), er);
        check(ef ? "R9 lanes" : {req, " lanes"}, int'(lanes_o), el);
        @(negedge clk);
        check("R10 done drops", int'(done_o), 0);
        check("R10 fail drops", int'(fail_o), 0);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int rates[5] = '{'h06, 'h0A, 'h14, 'h00, 'h0B};
        int mrates[3] = '{'h06, 'h0A, 'h14};
        int mlanes[3] = '{1, 2, 4};
        repeat (3) @(negedge clk);
        check("R1 done", int'(done_o), 0);
        check("R1 fail", int'(fail_o), 0);
        check("R1 rate", int'(rate_o), 0);
        check("R1 lanes", int'(lanes_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 idle done", int'(done_o), 0);

        foreach (rates[i])
            for (int l = 0; l < 8; l++)
                foreach (mrates[j])
                    foreach (mlanes[k])
                        one_step(rates[i], l, mrates[j], mlanes[k]);

        // R10: back-to-back steps, each with its own result
        @(negedge clk);
        cur_rate_i = 8'h14; cur_lanes_i = 3'd4; max_rate_i = 8'h14; max_lanes_i = 3'd4;
        step_i = 1'b1;
        @(negedge clk);
        check("R10 b2b first done", int'(done_o), 1);
        check("R10 b2b first lanes", int'(lanes_o), 2);
        cur_rate_i = 8'h0A; cur_lanes_i = 3'd0;
        @(negedge clk);
        step_i = 1'b0;
        check("R10 b2b second fail", int'(fail_o), 1);
        check("R10 b2b second rate", int'(rate_o), 'h0A);
        check("R10 b2b second lanes", int'(lanes_o), 0);
        @(negedge clk);
        check("R10 b2b idle", int'(done_o), 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule